// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits at the front of a double-precision fused multiply-add unit that computes z + x*y. When the negate-product control is set, it computes z - x*y instead. It sorts each of the three operands into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. It then decides whether the result follows from the classes and signs alone, without any arithmetic.

When the result is fixed by the operands, the block presents that result and flags any invalid operation. When it is not, the block raises a compute indication, and the multiply, alignment, add and rounding datapath downstream does the work. The rounding-mode input has one use only: it picks the sign of an exact zero sum.

Operands are captured on a clock edge where the input valid is high. All results are decoded from those captured registers and appear one cycle later, alongside an output valid.

Top module: `fma_special_resolver`

## Requirements
- R1: An operand set captured with `in_valid` high produces `out_valid` high on the following cycle. A cycle with `in_valid` low produces `out_valid` low on the following cycle. Reset clears `out_valid`.
- R2: While `out_valid` is high, exactly one of `out_special` and `out_compute` is high. While `out_valid` is low, both are low.
- R3: An operand is a signalling NaN when its exponent field is all ones, its fraction is nonzero and fraction bit 51 (the quiet bit) is 0. If any operand is a signalling NaN, the first one in the order z, x, y is returned with bit 51 set, and `out_invalid` is 1.
- R4: An operand is a quiet NaN when its exponent field is all ones and fraction bit 51 is 1. If no operand is a signalling NaN, the first quiet NaN in the order z, x, y is returned unchanged, and `out_invalid` is 0.
- R5: Infinity times zero, in either operand order, returns the indefinite NaN `INDEF_NAN` (default 0x7FF8000000000000) with `out_invalid` set.
- R6: The effective product sign is sign(x) XOR sign(y) XOR `neg_prod`. If the product is infinite and z is an infinity whose sign differs from the effective product sign, the result is `INDEF_NAN` with `out_invalid` set.
- R7: In every other case with an infinite product, the result is an infinity whose sign is the effective product sign: 0x7FF0000000000000, with bit 63 carrying that sign.
- R8: If the product is zero, and z is either infinite or finite and nonzero, z is returned unchanged.
- R9: If the product is zero and z is zero with the effective product sign, z is returned. If z is zero with the opposite sign, the result is a zero that is negative only when `rnd_mode` is 2'b11 (toward minus infinity).
- R10: If both x and y are finite and nonzero (denormals included) and z is infinite, z is returned unchanged.
- R11: If none of the cases above applies, `out_compute` is 1, `out_invalid` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture the operand set on this edge |
| op_z | input | 64 | Addend |
| op_x | input | 64 | First multiplicand |
| op_y | input | 64 | Second multiplicand |
| neg_prod | input | 1 | Negate the product (multiply-subtract form) |
| rnd_mode | input | 2 | Rounding mode; 2'b11 means toward minus infinity |
| out_valid | output | 1 | Result for the captured set is present |
| out_special | output | 1 | Result is fully determined by this block |
| out_compute | output | 1 | Arithmetic datapath must produce the result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_result | output | 64 | Determined result, zero when computing |

## Verification
Every result has a latency of exactly one cycle. The operands are captured on the rising edge that sees `in_valid`, and all outputs are decoded from those registers. The bench drives a new operand set at each falling edge and compares all outputs at the next falling edge. That point is half a cycle after the capturing edge, so the outputs are settled and have not yet moved on to the next set. After the final set, `in_valid` is dropped, and the next falling edge is used to confirm that `out_valid` has cleared.

// File: rtl/fmares_pkg.sv
package fmares_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5
  } op_class_e;

  localparam logic [1:0] RM_NEAREST  = 2'b00;
  localparam logic [1:0] RM_TO_ZERO  = 2'b01;
  localparam logic [1:0] RM_TO_POS   = 2'b10;
  localparam logic [1:0] RM_TO_NEG   = 2'b11;

  localparam int NUM_OPS = 3;
  localparam int IDX_Z   = 0;
  localparam int IDX_X   = 1;
  localparam int IDX_Y   = 2;

endpackage

// File: rtl/fmares_classify.sv
module fmares_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]          op,
  output fmares_pkg::op_class_e cls
);
  import fmares_pkg::*;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = op[W-2:FRAC_W];
  assign frac_f = op[FRAC_W-1:0];

  always_comb begin
    if (&exp_f) begin
      if (frac_f == '0)             cls = CLS_INF;
      else if (frac_f[FRAC_W-1])    cls = CLS_QNAN;
      else                          cls = CLS_SNAN;
    end else if (exp_f == '0) begin
      cls = (frac_f == '0) ? CLS_ZERO : CLS_DENORM;
    end else begin
      cls = CLS_NORMAL;
    end
  end

endmodule

// File: rtl/fmares_nan_pick.sv
module fmares_nan_pick #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int N     = fmares_pkg::NUM_OPS
) (
  input  logic [N-1:0][W-1:0]                ops,
  input  fmares_pkg::op_class_e [N-1:0]      cls,
  output logic                               nan_hit,
  output logic                               nan_invalid,
  output logic [W-1:0]                       nan_value
);
  import fmares_pkg::*;

  localparam logic [W-1:0] QUIET_MASK = W'(1) << (FRAC_W - 1);

  logic         snan_hit;
  logic         qnan_hit;
  logic [W-1:0] snan_val;
  logic [W-1:0] qnan_val;

  // Scan from the last operand down so the lowest index (z) wins.
  always_comb begin
    snan_hit = 1'b0;
    qnan_hit = 1'b0;
    snan_val = '0;
    qnan_val = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cls[i] == CLS_SNAN) begin
        snan_hit = 1'b1;
        snan_val = ops[i] | QUIET_MASK;
      end
      if (cls[i] == CLS_QNAN) begin
        qnan_hit = 1'b1;
        qnan_val = ops[i];
      end
    end
  end

  assign nan_hit     = snan_hit | qnan_hit;
  assign nan_invalid = snan_hit;
  assign nan_value   = snan_hit ? snan_val : qnan_val;

endmodule

// File: rtl/fmares_decide.sv
module fmares_decide #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W,
  parameter logic [W-1:0] INDEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
) (
  input  fmares_pkg::op_class_e cls_z,
  input  fmares_pkg::op_class_e cls_x,
  input  fmares_pkg::op_class_e cls_y,
  input  logic                  sign_x,
  input  logic                  sign_y,
  input  logic                  neg_prod,
  input  logic [1:0]            rnd_mode,
  input  logic [W-1:0]          op_z,
  input  logic                  nan_hit,
  input  logic                  nan_invalid,
  input  logic [W-1:0]          nan_value,
  output logic                  determined,
  output logic                  invalid,
  output logic [W-1:0]          result
);
  import fmares_pkg::*;

  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic eff_sign;
  logic sign_z;
  logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;
  logic prod_bad, prod_inf, prod_zero;

  assign sign_z    = op_z[W-1];
  assign eff_sign  = sign_x ^ sign_y ^ neg_prod;
  assign x_inf     = (cls_x == CLS_INF);
  assign y_inf     = (cls_y == CLS_INF);
  assign x_zero    = (cls_x == CLS_ZERO);
  assign y_zero    = (cls_y == CLS_ZERO);
  assign z_inf     = (cls_z == CLS_INF);
  assign z_zero    = (cls_z == CLS_ZERO);
  assign prod_bad  = (x_inf & y_zero) | (x_zero & y_inf);
  assign prod_inf  = x_inf | y_inf;
  assign prod_zero = x_zero | y_zero;

  always_comb begin
    determined = 1'b1;
    invalid    = 1'b0;
    result     = '0;
    if (nan_hit) begin
      invalid = nan_invalid;
      result  = nan_value;
    end else if (prod_bad) begin
      invalid = 1'b1;
      result  = INDEF_NAN;
    end else if (prod_inf) begin
      if (z_inf && (sign_z != eff_sign)) begin
        invalid = 1'b1;
        result  = INDEF_NAN;
      end else begin
        result = {eff_sign, INF_MAG};
      end
    end else if (prod_zero) begin
      if (z_zero && (sign_z != eff_sign)) result = {(rnd_mode == RM_TO_NEG), {(W-1){1'b0}}};
      else                                 result = op_z;
    end else if (z_inf) begin
      result = op_z;
    end else begin
      determined = 1'b0;
    end
  end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter logic [1+EXP_W+FRAC_W-1:0] INDEF_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [1+EXP_W+FRAC_W-1:0]  op_z,
  input  logic [1+EXP_W+FRAC_W-1:0]  op_x,
  input  logic [1+EXP_W+FRAC_W-1:0]  op_y,
  input  logic                       neg_prod,
  input  logic [1:0]                 rnd_mode,
  output logic                       out_valid,
  output logic                       out_special,
  output logic                       out_compute,
  output logic                       out_invalid,
  output logic [1+EXP_W+FRAC_W-1:0]  out_result
);
  import fmares_pkg::*;

  localparam int W = 1 + EXP_W + FRAC_W;
  localparam int N = NUM_OPS;

  logic                 valid_q;
  logic [N-1:0][W-1:0]  ops_q;
  logic                 neg_q;
  logic [1:0]           rm_q;
  op_class_e [N-1:0]    cls;
  logic                 nan_hit, nan_inv;
  logic [W-1:0]         nan_val;
  logic                 det, inv;
  logic [W-1:0]         res;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= in_valid;
    if (in_valid) begin
      ops_q[IDX_Z] <= op_z;
      ops_q[IDX_X] <= op_x;
      ops_q[IDX_Y] <= op_y;
      neg_q        <= neg_prod;
      rm_q         <= rnd_mode;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cls
    fmares_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (ops_q[i]),
      .cls (cls[i])
    );
  end

  fmares_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
    .ops         (ops_q),
    .cls         (cls),
    .nan_hit     (nan_hit),
    .nan_invalid (nan_inv),
    .nan_value   (nan_val)
  );

  fmares_decide #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INDEF_NAN(INDEF_NAN)) u_dec (
    .cls_z       (cls[IDX_Z]),
    .cls_x       (cls[IDX_X]),
    .cls_y       (cls[IDX_Y]),
    .sign_x      (ops_q[IDX_X][W-1]),
    .sign_y      (ops_q[IDX_Y][W-1]),
    .neg_prod    (neg_q),
    .rnd_mode    (rm_q),
    .op_z        (ops_q[IDX_Z]),
    .nan_hit     (nan_hit),
    .nan_invalid (nan_inv),
    .nan_value   (nan_val),
    .determined  (det),
    .invalid     (inv),
    .result      (res)
  );

  assign out_valid   = valid_q;
  assign out_special = valid_q & det;
  assign out_compute = valid_q & ~det;
  assign out_invalid = valid_q & inv;
  assign out_result  = res;

  // R1: valid follows the capture by one cycle
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R2: exactly one path when valid, none when idle
  assert_one_path_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_special ^ out_compute));
  assert_no_path_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_special && !out_compute));
  // R3/R4: any NaN leaving the block is quiet
  assert_nan_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (out_special && (&out_result[W-2:FRAC_W]) && (out_result[FRAC_W-1:0] != '0))
      |-> out_result[FRAC_W-1]);
  // R5/R6: invalid only on a determined result
  assert_invalid_special_R5: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> out_special);
  // R11: compute path carries no result and no flag
  assert_compute_clean_R11: assert property (@(posedge clk) disable iff (rst)
    out_compute |-> (out_result == '0 && !out_invalid));

endmodule

// File: tb/fma_special_resolver_test.sv
module fma_special_resolver_test;

  localparam logic [63:0] INDEF = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] op_z, op_x, op_y;
  logic        neg_prod;
  logic [1:0]  rnd_mode;
  logic        out_valid, out_special, out_compute, out_invalid;
  logic [63:0] out_result;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fma_special_resolver uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_z(op_z), .op_x(op_x), .op_y(op_y),
    .neg_prod(neg_prod), .rnd_mode(rnd_mode),
    .out_valid(out_valid), .out_special(out_special), .out_compute(out_compute),
    .out_invalid(out_invalid), .out_result(out_result)
  );

  // class codes for stimulus: 0 zero,1 denorm,2 normal,3 inf,4 qnan,5 snan
  function automatic logic [63:0] make_op(int c, logic s);
    logic [51:0] f;
    logic [10:0] e;
    f = {$urandom, $urandom} & 52'hF_FFFF_FFFF_FFFF;
    case (c)
      0: return {s, 63'd0};
      1: return {s, 11'd0, f | 52'd1};
      2: begin e = 11'($urandom_range(1, 2046)); return {s, e, f}; end
      3: return {s, 11'h7FF, 52'd0};
      4: return {s, 11'h7FF, 1'b1, f[50:0]};
      default: return {s, 11'h7FF, 1'b0, f[50:0] | 51'd1};
    endcase
  endfunction

  function automatic bit is_inf(logic [63:0] v);  return v[62:0] == PINF[62:0]; endfunction
  function automatic bit is_zero(logic [63:0] v); return v[62:0] == 63'd0;      endfunction
  function automatic bit is_snan(logic [63:0] v);
    return v[62:52] == 11'h7FF && !v[51] && v[50:0] != 0;
  endfunction
  function automatic bit is_qnan(logic [63:0] v);
    return v[62:52] == 11'h7FF && v[51];
  endfunction

  task automatic reference(input logic [63:0] z, x, y, input logic ng, input logic [1:0] rm,
                           output bit sp, output bit inv, output logic [63:0] res,
                           output string tag);
    logic ps;
    ps = x[63] ^ y[63] ^ ng;
    sp = 1'b1; inv = 1'b0; res = 64'd0;
    if (is_snan(z) || is_snan(x) || is_snan(y)) begin
      tag = "R3"; inv = 1'b1;
      res = is_snan(z) ? z : (is_snan(x) ? x : y);
      res[51] = 1'b1;
    end else if (is_qnan(z) || is_qnan(x) || is_qnan(y)) begin
      tag = "R4";
      res = is_qnan(z) ? z : (is_qnan(x) ? x : y);
    end else if ((is_inf(x) && is_zero(y)) || (is_zero(x) && is_inf(y))) begin
      tag = "R5"; inv = 1'b1; res = INDEF;
    end else if (is_inf(x) || is_inf(y)) begin
      if (is_inf(z) && z[63] != ps) begin tag = "R6"; inv = 1'b1; res = INDEF; end
      else begin tag = "R7"; res = PINF | {ps, 63'd0}; end
    end else if (is_zero(x) || is_zero(y)) begin
      if (is_zero(z)) begin
        tag = "R9";
        res = (z[63] == ps) ? z : {rm == 2'b11, 63'd0};
      end else begin tag = "R8"; res = z; end
    end else if (is_inf(z)) begin
      tag = "R10"; res = z;
    end else begin
      tag = "R11"; sp = 1'b0;
    end
  endtask

  task automatic apply(input logic [63:0] z, x, y, input logic ng, input logic [1:0] rm);
    bit e_sp, e_inv;
    logic [63:0] e_res;
    string tag;
    reference(z, x, y, ng, rm, e_sp, e_inv, e_res, tag);
    op_z = z; op_x = x; op_y = y; neg_prod = ng; rnd_mode = rm; in_valid = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b1 || out_special !== e_sp || out_compute !== !e_sp ||
        out_invalid !== e_inv || out_result !== e_res) begin
      bad++;
      $display("FAIL %s R1/R2: got v=%b sp=%b cp=%b inv=%b res=%h exp sp=%b inv=%b res=%h",
               tag, out_valid, out_special, out_compute, out_invalid, out_result,
               e_sp, e_inv, e_res);
    end
  endtask

  task automatic rand_vec();
    int cz, cx, cy;
    cz = ($urandom_range(0, 9) < 4) ? 2 : $urandom_range(0, 5);
    cx = ($urandom_range(0, 9) < 4) ? 2 : $urandom_range(0, 5);
    cy = ($urandom_range(0, 9) < 4) ? 2 : $urandom_range(0, 5);
    apply(make_op(cz, 1'($urandom)), make_op(cx, 1'($urandom)), make_op(cy, 1'($urandom)),
          1'($urandom), 2'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1: got no completion expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] one, two, qa, qb, sa, sb;
    void'($urandom(32'd2024));
    rst = 1'b1; in_valid = 1'b0; op_z = '0; op_x = '0; op_y = '0;
    neg_prod = 1'b0; rnd_mode = 2'b00;
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_special !== 1'b0 || out_compute !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: got v=%b sp=%b cp=%b expected 0 0 0",
               out_valid, out_special, out_compute);
    end
    rst = 1'b0;
    @(negedge clk);

    one = 64'h3FF0_0000_0000_0000;
    two = 64'h4000_0000_0000_0000;
    qa  = 64'h7FF8_0000_0000_00AA;
    qb  = 64'hFFF8_0000_0000_00BB;
    sa  = 64'h7FF0_0000_0000_0011;
    sb  = 64'hFFF0_0000_0000_0022;

    // R3 precedence: z before x before y, signalling before quiet
    apply(sa, sb, qa, 1'b0, 2'b00);
    apply(qa, sb, sa, 1'b0, 2'b00);
    apply(one, qb, sa, 1'b0, 2'b00);
    // R4 precedence among quiet NaNs
    apply(qb, qa, one, 1'b0, 2'b00);
    apply(one, one, qa, 1'b0, 2'b00);
    // R5 both orders, even with z infinite
    apply(one, PINF, 64'd0, 1'b0, 2'b00);
    apply(PINF, 64'h8000_0000_0000_0000, PINF, 1'b1, 2'b00);
    // R6 and R7 with and without negate
    apply({1'b1, PINF[62:0]}, PINF, two, 1'b0, 2'b00);
    apply(PINF, PINF, two, 1'b1, 2'b00);
    apply(PINF, PINF, two, 1'b0, 2'b00);
    apply(one, PINF, two, 1'b1, 2'b00);
    // R8
    apply(two, 64'd0, one, 1'b0, 2'b00);
    apply({1'b1, PINF[62:0]}, 64'd0, one, 1'b0, 2'b00);
    // R9 signed zeros across rounding modes
    apply(64'd0, 64'h8000_0000_0000_0000, one, 1'b0, 2'b11);
    apply(64'd0, 64'h8000_0000_0000_0000, one, 1'b0, 2'b00);
    apply(64'd0, 64'd0, one, 1'b1, 2'b11);
    apply(64'h8000_0000_0000_0000, 64'd0, one, 1'b1, 2'b10);
    // R10 with denormal multiplicand
    apply(PINF, 64'h0000_0000_0000_0001, two, 1'b1, 2'b00);
    // R11
    apply(one, one, two, 1'b0, 2'b00);
    apply(64'd0, 64'h0000_0000_0000_0005, two, 1'b1, 2'b11);

    for (int i = 0; i < 3000; i++) rand_vec();

    in_valid = 1'b0;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_special !== 1'b0 || out_compute !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle: got v=%b sp=%b cp=%b expected 0 0 0",
               out_valid, out_special, out_compute);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule